// File: doc/BRIEF.md
# Page Access Permission Checker

This unit sits after address translation and decides, for each memory access, whether the access may proceed or must raise a page fault. Each request carries the privilege of the requester (user or supervisor), the kind of access (read, write or instruction fetch) and three permission bits from the translated page entry: present, writable and user-accessible. One cycle after it accepts a request, the unit returns a registered verdict: a grant, or a fault with a three-bit reason code.

The unit holds one control register with a write-protect enable flag. This flag decides whether supervisor code may write to read-only pages. Operating-system software normally leaves the flag set, so that a kernel write to a shared read-only page traps and a private copy of the page can be made first. Software may clear the flag for a short time to edit protected mappings. A simple configuration port reads and writes the register. Register index 1 is reserved and is reported as an illegal access.

Top module: `pg_access_chk`

## Requirements
- R1: Configuration index 0 is the control register. Write-protect sits at bit 16. A read returns write-protect at bit 16 and zero in every other bit. A write updates only bit 16, and all other written bits are ignored.
- R2: After reset, write-protect is 1, so a read of index 0 returns 0x00010000.
- R3: With write-protect at 1, a supervisor write (kind 2'b01, req_user=0) to a present page whose writable bit is 0 faults with code 3'b011.
- R4: With write-protect at 0, a supervisor write to a present read-only page is granted, whether the page's user bit is 0 or 1.
- R5: A user write (req_user=1) to a present, user-accessible page whose writable bit is 0 faults with code 3'b111, whatever the write-protect value.
- R6: A user access of any kind to a present page whose user bit is 0 faults. Code bit 0 is 1, bit 1 is 1 only for writes, and bit 2 is 1.
- R7: An access to a page whose present bit is 0 faults before any other check. Code bit 0 is 0, bit 1 marks a write, and bit 2 marks user mode.
- R8: A read (kind 2'b00) or fetch (kind 2'b10, with 2'b11 handled as a read) to a present page the requester may access is granted, whatever the write-protect value. A granted verdict carries code 3'b000.
- R9: req_ready equals !rsp_valid || rsp_ready. Each accepted request produces exactly one verdict, in the cycle after acceptance. The verdict stays stable while rsp_valid is high and rsp_ready is low.
- R10: A configuration access to any index other than 0, including reserved index 1, raises cfg_illegal in the following cycle, returns cfg_rdata of zero and changes no state.
- R11: A write to write-protect applies to requests accepted on later clock edges. A request accepted on the same edge as the write is judged with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| pte_present | input | 1 | Page entry present bit |
| pte_writable | input | 1 | Page entry writable bit |
| pte_user | input | 1 | Page entry user-accessible bit |
| rsp_valid | output | 1 | Verdict available |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access raises a page fault |
| rsp_code | output | 3 | bit0 protection (0 = not present), bit1 write, bit2 user |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | 3 | Control register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data, one cycle after the strobe |
| cfg_illegal | output | 1 | Pulses one cycle after an access to an unimplemented index |

## Verification
The bench targets a supervisor write to a read-only page under both write-protect values. A design that ignores the flag would either always trap kernel writes or let them through silently. It also covers user writes to read-only pages after write-protect is cleared, where a shared permission path would wrongly grant them. It checks not-present pages that are also read-only or supervisor-only, where a design with the wrong check order would report a protection code instead of a not-present code. It sends a request on the same edge as a write-protect change, to catch a design that applies the new flag too early. It sets unused bits when writing index 0 and writes to reserved index 1, which a sloppy register would let through. Random-like back-pressure on rsp_ready tests that verdicts are neither dropped, duplicated nor changed while stalled.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_kind_e;

    localparam int unsigned CODE_W   = 3;
    localparam int unsigned FC_PROT  = 0;
    localparam int unsigned FC_WRITE = 1;
    localparam int unsigned FC_USER  = 2;

    typedef struct packed {
        logic              grant;
        logic [CODE_W-1:0] code;
    } verdict_t;

endpackage

// File: rtl/pac_ctrl_reg.sv
module pac_ctrl_reg #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned WP_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_illegal,
    output logic              wp
);

    localparam logic [IDX_W-1:0] CTRL_IDX = '0;
    localparam logic [IDX_W-1:0] RSVD_IDX = IDX_W'(1);

    typedef struct packed {
        logic              wp;
        logic              illegal;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [DATA_W-1:0] ctrl_view;

    // Compose the readable image: only the write-protect position is live.
    for (genvar i = 0; i < DATA_W; i++) begin : g_view
        if (i == WP_BIT) begin : g_live
            assign ctrl_view[i] = st_q.wp;
        end else begin : g_zero
            assign ctrl_view[i] = 1'b0;
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        st_d.rdata   = '0;
        if (cfg_en) begin
            if (cfg_idx == CTRL_IDX) begin
                if (cfg_we) begin
                    st_d.wp = cfg_wdata[WP_BIT];
                end else begin
                    st_d.rdata = ctrl_view;
                end
            end else begin
                st_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wp      <= 1'b1;
            st_q.illegal <= 1'b0;
            st_q.rdata   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata   = st_q.rdata;
    assign cfg_illegal = st_q.illegal;
    assign wp          = st_q.wp;

    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en && (cfg_idx == RSVD_IDX) |=> cfg_illegal && (cfg_rdata == '0)); // R10
    AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en && cfg_we && (cfg_idx != CTRL_IDX) |=> $stable(wp)); // R10

endmodule

// File: rtl/pac_perm_eval.sv
module pac_perm_eval
    import pac_pkg::*;
(
    input  logic      wp,
    input  logic      is_user,
    input  logic [1:0] kind,
    input  logic      present,
    input  logic      writable,
    input  logic      user_ok,
    output verdict_t  verdict
);

    logic is_write;
    logic deny;

    always_comb begin
        is_write = (kind == ACC_WRITE);
        deny     = 1'b0;
        verdict  = '0;
        if (!present) begin
            deny = 1'b1;
        end else if (is_user && !user_ok) begin
            deny = 1'b1;
        end else if (is_write && !writable) begin
            // User writes to read-only pages always trap; supervisor ones follow wp.
            deny = is_user | wp;
        end
        verdict.grant = !deny;
        if (deny) begin
            verdict.code[FC_PROT]  = present;
            verdict.code[FC_WRITE] = is_write;
            verdict.code[FC_USER]  = is_user;
        end
    end

endmodule

// File: rtl/pac_rsp_stage.sv
module pac_rsp_stage
    import pac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  verdict_t          verdict,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_code
);

    typedef struct packed {
        logic     valid;
        verdict_t v;
    } rsp_state_t;

    rsp_state_t st_d, st_q;
    logic       take;

    always_comb begin
        st_d      = st_q;
        req_ready = !st_q.valid || rsp_ready;
        take      = req_valid && req_ready;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.v     = verdict;
        end else if (rsp_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_grant = st_q.valid &&  st_q.v.grant;
    assign rsp_fault = st_q.valid && !st_q.v.grant;
    assign rsp_code  = st_q.v.code;

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_grant) && $stable(rsp_code)); // R9
    AST_ACCEPT_GIVES_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid); // R9
    AST_GRANT_CLEAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_code == '0); // R8

endmodule

// File: rtl/pg_access_chk.sv
module pg_access_chk
    import pac_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned WP_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_user,
    input  logic [1:0]        req_kind,
    input  logic              pte_present,
    input  logic              pte_writable,
    input  logic              pte_user,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic [2:0]        rsp_code,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_illegal
);

    logic     wp;
    verdict_t verdict;

    pac_ctrl_reg #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .WP_BIT (WP_BIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .cfg_illegal (cfg_illegal),
        .wp          (wp)
    );

    pac_perm_eval u_eval (
        .wp       (wp),
        .is_user  (req_user),
        .kind     (req_kind),
        .present  (pte_present),
        .writable (pte_writable),
        .user_ok  (pte_user),
        .verdict  (verdict)
    );

    pac_rsp_stage u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .verdict   (verdict),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_grant (rsp_grant),
        .rsp_fault (rsp_fault),
        .rsp_code  (rsp_code)
    );

    AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !pte_present |=> rsp_fault && !rsp_code[0]); // R7
    AST_USER_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_user && (req_kind == ACC_WRITE)
        && pte_present && pte_user && !pte_writable |=> rsp_fault && (rsp_code == 3'b111)); // R5
    AST_SUP_WRITE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_user && (req_kind == ACC_WRITE)
        && pte_present && !pte_writable && wp |=> rsp_fault && (rsp_code == 3'b011)); // R3
    AST_SUP_WRITE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_user && (req_kind == ACC_WRITE)
        && pte_present && !wp |=> rsp_grant); // R4

endmodule

// File: tb/tb_pg_access_chk.sv
module tb_pg_access_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_user = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        pte_present = 1'b0, pte_writable = 1'b0, pte_user = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_fault;
    logic        rsp_ready = 1'b1;
    logic [2:0]  rsp_code;
    logic        cfg_en = 1'b0, cfg_we = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        cfg_illegal;

    int   checks = 0;
    int   fails  = 0;
    logic wp_m   = 1'b1;
    bit   bp_on  = 1'b0;
    int   bp_cnt = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    pg_access_chk dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_user(req_user), .req_kind(req_kind),
        .pte_present(pte_present), .pte_writable(pte_writable), .pte_user(pte_user),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_illegal(cfg_illegal)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Reference verdict {grant, code} built from the requirement text.
    function automatic logic [3:0] model(input logic wp, input logic u, input logic [1:0] k,
                                         input logic p, input logic w, input logic pu);
        logic wr;
        logic deny;
        wr = (k == 2'b01);
        if (!p)                deny = 1'b1;
        else if (u && !pu)     deny = 1'b1;
        else if (wr && !w)     deny = u ? 1'b1 : wp;
        else                   deny = 1'b0;
        return deny ? {1'b0, u, wr, p} : 4'b1000;
    endfunction

    task automatic send(input logic u, input logic [1:0] k, input logic p,
                        input logic w, input logic pu, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_user = u; req_kind = k;
        pte_present = p; pte_writable = w; pte_user = pu;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(wp_m, u, k, p, w, pu));
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic cfg_access(input logic we, input logic [2:0] idx, input logic [31:0] data,
                              input logic [31:0] exp_rd, input logic exp_ill, input string tag);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = we; cfg_idx = idx; cfg_wdata = data;
        @(posedge clk);
        #1;
        cfg_en = 1'b0;
        if (we && idx == 3'd0) wp_m = data[16];
        @(negedge clk);
        check(cfg_illegal == exp_ill, {tag, " illegal flag"}, 32'(cfg_illegal), 32'(exp_ill));
        check(cfg_rdata == exp_rd, {tag, " read data"}, cfg_rdata, exp_rd);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Consumer ready, changed away from both clock edges used elsewhere.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            rsp_ready = bp_on ? ((bp_cnt % 3) != 0) : 1'b1;
            bp_cnt++;
        end
    end

    // Monitor / scoreboard.
    initial begin
        logic       prev_stall = 1'b0;
        logic [3:0] prev_val   = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stall) begin
                    check(rsp_valid && ({rsp_grant, rsp_code} == prev_val), "R9 stalled verdict held",
                          32'({rsp_valid, rsp_grant, rsp_code}), 32'({1'b1, prev_val}));
                end
                if (rsp_valid) begin
                    check(rsp_grant != rsp_fault, "R9 grant xor fault",
                          32'({rsp_grant, rsp_fault}), 32'b10);
                end
                if (rsp_valid && rsp_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 unexpected verdict", 32'({rsp_grant, rsp_code}), 32'hFFFF);
                    end else begin
                        logic [3:0] e;
                        string      t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({rsp_grant, rsp_code} == e, t, 32'({rsp_grant, rsp_code}), 32'(e));
                    end
                end
                prev_stall = rsp_valid && !rsp_ready;
                prev_val   = {rsp_grant, rsp_code};
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R9 no verdict after reset", 32'(rsp_valid), 32'd0);
        cfg_access(1'b0, 3'd0, 32'd0, 32'h0001_0000, 1'b0, "R2 reset write-protect");

        // Grants on accessible pages (wp=1).
        send(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, "R8 supervisor read RO");
        send(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, "R8 user fetch");
        send(1'b1, 2'b11, 1'b1, 1'b0, 1'b1, "R8 user alt-kind read");
        send(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, "R8 user write RW");
        // Write-protect traps supervisor writes.
        send(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, "R3 sup write RO sup page");
        send(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, "R3 sup write RO user page");
        send(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, "R5 user write RO wp=1");
        send(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, "R6 user read sup page");
        send(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, "R6 user write sup page");
        send(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, "R6 user fetch sup page");
        send(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, "R7 user write absent");
        send(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, "R7 sup read absent");
        send(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, "R7 sup write absent RO");
        drain();

        // Reserved index and register field isolation.
        cfg_access(1'b1, 3'd1, 32'h0000_0000, 32'd0, 1'b1, "R10 write reserved index");
        cfg_access(1'b0, 3'd0, 32'd0, 32'h0001_0000, 1'b0, "R10 wp unchanged");
        cfg_access(1'b0, 3'd1, 32'd0, 32'd0, 1'b1, "R10 read reserved index");
        cfg_access(1'b1, 3'd5, 32'h0000_0000, 32'd0, 1'b1, "R10 write unimplemented index");
        cfg_access(1'b1, 3'd0, 32'hFFFF_FFFF, 32'd0, 1'b0, "R1 write all ones");
        cfg_access(1'b0, 3'd0, 32'd0, 32'h0001_0000, 1'b0, "R1 only bit 16 kept");
        cfg_access(1'b1, 3'd0, 32'hFFFE_FFFF, 32'd0, 1'b0, "R1 clear bit 16");
        cfg_access(1'b0, 3'd0, 32'd0, 32'h0000_0000, 1'b0, "R1 wp now clear");

        // wp=0 behaviour.
        send(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, "R4 sup write RO sup page");
        send(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, "R4 sup write RO user page");
        send(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, "R5 user write RO wp=0");
        send(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, "R8 user read wp=0");
        send(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, "R7 absent wins wp=0");
        drain();

        // Same-edge flag change: old value applies to the request taken on that edge.
        @(negedge clk);
        req_valid = 1'b1; req_user = 1'b0; req_kind = 2'b01;
        pte_present = 1'b1; pte_writable = 1'b0; pte_user = 1'b0;
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 32'h0001_0000;
        #1;
        check(req_ready == 1'b1, "R11 ready for same-edge request", 32'(req_ready), 32'd1);
        exp_q.push_back(model(wp_m, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0));
        tag_q.push_back("R11 request on write edge uses old flag");
        @(posedge clk);
        #1;
        req_valid = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0;
        wp_m = 1'b1;
        send(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, "R11 next request uses new flag");
        drain();

        // Back-pressure with a mixed stream.
        bp_on = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic [4:0] s;
            s = 5'(i * 7 + 3);
            send(s[0], s[2:1], s[3] | s[4], s[4], s[0] ^ s[3], "R9 stream under back-pressure");
        end
        drain();
        bp_on = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all verdicts delivered", 32'(exp_q.size()), 32'd0);

        summary();
        $finish;
    end

endmodule